// File: doc/BRIEF.md
# Modulo-N Reload Down Counter with Seven-Segment Output

This block is a small synchronous down counter. Each clock it steps the count down by one. A synchronous clear returns it to zero, and a parallel load takes a new count from a data input. A terminal-count flag goes high whenever the count is zero. When auto-reload is enabled, that flag acts as an internal load of the constant `MOD_N-1`. The counter then repeats a cycle of exactly `MOD_N` states: `MOD_N-1` down to 0.

A combinational decoder turns the count into a seven-segment pattern for a single digit. The block suits simple timebases, periodic strobes and front-panel step counters.

The count width and the modulo value are parameters. A modulo value that does not fit the count width stops elaboration.

Top module: `modn_down_counter`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the count becomes 0 after that edge.
- R2: When `clr` is high at a clock edge, the count becomes 0 after that edge. This holds whatever the values of `load_req`, `load_val` and `auto_en`.
- R3: When `clr` is low and `load_req` is high, the next count equals `load_val`. An external load wins over an auto-reload due in the same cycle.
- R4: When none of clear, external load or auto-reload applies, the count decrements by one per clock. It wraps from 0 to all ones (7 at the default width of 3).
- R5: `tmo` is combinational and is 1 exactly when the count is 0.
- R6: When `clr` and `load_req` are low, `auto_en` is high and the count is 0, the next count is `MOD_N-1` (4 by default). Left alone, the counter therefore repeats a cycle of `MOD_N` states.
- R7: `seg[6:0]` drives the segments a..g, with a at bit 6. Counts 0 to 7 map to hex 7E, 30, 6D, 79, 33, 5B, 5F, 70. Any count above 7 gives 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear, highest priority |
| load_req | input | 1 | External parallel load request |
| load_val | input | CNT_W | Value taken on an external load |
| auto_en | input | 1 | Enables reload of MOD_N-1 on terminal count |
| count | output | CNT_W | Current count |
| tmo | output | 1 | Terminal count, high when count is 0 |
| seg | output | 7 | Seven-segment pattern, bit 6 = a, bit 0 = g |

## Verification
The counter is driven with four patterns:
- A clear followed by free decrementing through the wrap. This separates correct wrap from an early reload.
- A mid-sequence external load of 5 that runs down to terminal count. This checks that `tmo` rises only at zero.
- Clear and load asserted together, and a load asserted while auto-reload is armed. These pin down the priority order.
- Auto-reload run over more than two full cycles. This confirms the cycle length is exactly `MOD_N`.

Every count value from 0 to 7 is then loaded, and its segment pattern is compared with the expected code.

// File: rtl/modn_pkg.sv
package modn_pkg;

    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_LOAD  = 2'd1,
        OP_AUTO  = 2'd2,
        OP_DEC   = 2'd3
    } cnt_op_e;

    localparam logic [6:0] SEG_BLANK = 7'h00;

    // segment order a..g, a in bit 6
    function automatic logic [6:0] seg7_pattern(input logic [2:0] digit);
        logic [6:0] p;
        case (digit)
            3'd0:    p = 7'h7E;
            3'd1:    p = 7'h30;
            3'd2:    p = 7'h6D;
            3'd3:    p = 7'h79;
            3'd4:    p = 7'h33;
            3'd5:    p = 7'h5B;
            3'd6:    p = 7'h5F;
            default: p = 7'h70;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/modn_next_state.sv
module modn_next_state
    import modn_pkg::*;
#(
    parameter int CNT_W = 3,
    parameter logic [CNT_W-1:0] RELOAD = '0
) (
    input  logic             clr,
    input  logic             load_req,
    input  logic [CNT_W-1:0] load_val,
    input  logic             auto_en,
    input  logic [CNT_W-1:0] cur,
    output logic [CNT_W-1:0] nxt,
    output logic             at_zero
);

    cnt_op_e op;

    always_comb begin
        at_zero = (cur == '0);
        if (clr)                    op = OP_CLEAR;
        else if (load_req)          op = OP_LOAD;
        else if (auto_en && at_zero) op = OP_AUTO;
        else                        op = OP_DEC;
    end

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = load_val;
            OP_AUTO:  nxt = RELOAD;
            default:  nxt = cur - CNT_W'(1);
        endcase
    end

endmodule

// File: rtl/modn_count_reg.sv
module modn_count_reg #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] d,
    output logic [CNT_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

endmodule

// File: rtl/modn_seg_decoder.sv
module modn_seg_decoder
    import modn_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic [CNT_W-1:0] value,
    output logic [6:0]       seg
);

    logic over_range;

    generate
        if (CNT_W > 3) begin : g_wide
            assign over_range = |value[CNT_W-1:3];
        end else begin : g_narrow
            assign over_range = 1'b0;
        end
    endgenerate

    always_comb begin
        if (over_range) seg = SEG_BLANK;
        else            seg = seg7_pattern(value[2:0]);
    end

endmodule

// File: rtl/modn_down_counter.sv
module modn_down_counter
    import modn_pkg::*;
#(
    parameter int CNT_W = 3,
    parameter int MOD_N = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load_req,
    input  logic [CNT_W-1:0] load_val,
    input  logic             auto_en,
    output logic [CNT_W-1:0] count,
    output logic             tmo,
    output logic [6:0]       seg
);

    localparam logic [CNT_W-1:0] RELOAD_V = CNT_W'(MOD_N - 1);

    generate
        if (CNT_W < 3 || MOD_N < 1 || MOD_N > (1 << CNT_W)) begin : g_bad_cfg
            $error("modn_down_counter: MOD_N must lie in 1..2**CNT_W and CNT_W >= 3");
        end
    endgenerate

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             zero_flag;

    modn_next_state #(
        .CNT_W  (CNT_W),
        .RELOAD (RELOAD_V)
    ) u_next (
        .clr      (clr),
        .load_req (load_req),
        .load_val (load_val),
        .auto_en  (auto_en),
        .cur      (cnt_q),
        .nxt      (cnt_d),
        .at_zero  (zero_flag)
    );

    modn_count_reg #(
        .CNT_W (CNT_W)
    ) u_reg (
        .clk (clk),
        .rst (rst),
        .d   (cnt_d),
        .q   (cnt_q)
    );

    modn_seg_decoder #(
        .CNT_W (CNT_W)
    ) u_seg (
        .value (cnt_q),
        .seg   (seg)
    );

    assign count = cnt_q;
    assign tmo   = zero_flag;

endmodule

// File: rtl/modn_down_counter_chk.sv
module modn_down_counter_chk #(
    parameter int CNT_W = 3,
    parameter int MOD_N = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             load_req,
    input logic [CNT_W-1:0] load_val,
    input logic             auto_en,
    input logic [CNT_W-1:0] count,
    input logic             tmo,
    input logic [6:0]       seg
);

    localparam logic [CNT_W-1:0] EXP_RELOAD = CNT_W'(MOD_N - 1);

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (count == '0));

    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0));

    assert_ext_load_R3: assert property (@(posedge clk) disable iff (rst)
        (!clr && load_req) |=> (count == $past(load_val)));

    assert_decrement_R4: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load_req && !(auto_en && tmo)) |=> (count == $past(count) - CNT_W'(1)));

    assert_tmo_zero_R5: assert property (@(posedge clk) disable iff (rst)
        tmo == (count == '0));

    assert_auto_reload_R6: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load_req && auto_en && tmo) |=> (count == EXP_RELOAD));

    assert_seg_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> (seg == 7'h7E));

endmodule

bind modn_down_counter modn_down_counter_chk #(
    .CNT_W (CNT_W),
    .MOD_N (MOD_N)
) u_chk (.*);

// File: tb/modn_down_counter_tb.sv
module modn_down_counter_tb;

    localparam int CNT_W = 3;
    localparam int MOD_N = 5;

    typedef struct packed {
        logic       clr;
        logic       ld;
        logic [2:0] val;
        logic       au;
        logic [2:0] exp;
    } vec_t;

    // count after the edge, starting from count 0 out of reset
    localparam int NV = 23;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0, 3'd0, 1'b0, 3'd0},  // R2 clear
        '{1'b0, 1'b0, 3'd0, 1'b0, 3'd7},  // R4 wrap
        '{1'b0, 1'b0, 3'd0, 1'b0, 3'd6},
        '{1'b0, 1'b0, 3'd0, 1'b0, 3'd5},
        '{1'b0, 1'b0, 3'd0, 1'b0, 3'd4},
        '{1'b0, 1'b0, 3'd0, 1'b0, 3'd3},
        '{1'b0, 1'b0, 3'd0, 1'b0, 3'd2},
        '{1'b0, 1'b1, 3'd5, 1'b0, 3'd5},  // R3 load
        '{1'b0, 1'b0, 3'd0, 1'b0, 3'd4},
        '{1'b0, 1'b0, 3'd0, 1'b0, 3'd3},
        '{1'b0, 1'b0, 3'd0, 1'b0, 3'd2},
        '{1'b0, 1'b0, 3'd0, 1'b0, 3'd1},
        '{1'b0, 1'b0, 3'd0, 1'b0, 3'd0},
        '{1'b0, 1'b0, 3'd0, 1'b0, 3'd7},  // R4 wrap without auto
        '{1'b1, 1'b1, 3'd3, 1'b1, 3'd0},  // R2 clear beats load
        '{1'b0, 1'b0, 3'd0, 1'b1, 3'd4},  // R6 reload
        '{1'b0, 1'b0, 3'd0, 1'b1, 3'd3},
        '{1'b0, 1'b0, 3'd0, 1'b1, 3'd2},
        '{1'b0, 1'b0, 3'd0, 1'b1, 3'd1},
        '{1'b0, 1'b0, 3'd0, 1'b1, 3'd0},
        '{1'b0, 1'b1, 3'd6, 1'b1, 3'd6},  // R3 load beats reload
        '{1'b0, 1'b0, 3'd0, 1'b1, 3'd5},
        '{1'b0, 1'b0, 3'd0, 1'b1, 3'd4}
    };

    logic [6:0] segtab [8];
    initial begin
        segtab[0] = 7'h7E; segtab[1] = 7'h30; segtab[2] = 7'h6D; segtab[3] = 7'h79;
        segtab[4] = 7'h33; segtab[5] = 7'h5B; segtab[6] = 7'h5F; segtab[7] = 7'h70;
    end

    logic             clk = 1'b0;
    logic             rst;
    logic             clr;
    logic             load_req;
    logic [CNT_W-1:0] load_val;
    logic             auto_en;
    logic [CNT_W-1:0] count;
    logic             tmo;
    logic [6:0]       seg;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    modn_down_counter #(.CNT_W(CNT_W), .MOD_N(MOD_N)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .load_req (load_req),
        .load_val (load_val),
        .auto_en  (auto_en),
        .count    (count),
        .tmo      (tmo),
        .seg      (seg)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic l, input logic [2:0] v, input logic a);
        clr = c; load_req = l; load_val = v; auto_en = a;
        @(posedge clk);
        #1;
    endtask

    task automatic check_outputs(input string req, input logic [2:0] exp);
        check(req, int'(count), int'(exp));
        check("R5 tmo", int'(tmo), int'(exp == 3'd0));
        check("R7 seg", int'(seg), int'(segtab[exp]));
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [2:0] m;
        rst = 1'b1; clr = 1'b0; load_req = 1'b0; load_val = '0; auto_en = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        check_outputs("R1 reset", 3'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(TBL[i].clr, TBL[i].ld, TBL[i].val, TBL[i].au);
            check_outputs("R2/R3/R4/R6 table", TBL[i].exp);
        end

        // R1: reset from a nonzero count
        rst = 1'b1;
        step(1'b0, 1'b0, 3'd0, 1'b0);
        check_outputs("R1 reset mid-count", 3'd0);
        rst = 1'b0;

        // R4: free run over two full wraps
        m = 3'd0;
        for (int i = 0; i < 16; i++) begin
            step(1'b0, 1'b0, 3'd0, 1'b0);
            m = m - 3'd1;
            check_outputs("R4 free wrap", m);
        end

        // R6: auto-reload for more than two full cycles
        step(1'b0, 1'b1, 3'd2, 1'b1);
        m = 3'd2;
        check_outputs("R3 load before auto", m);
        for (int i = 0; i < 13; i++) begin
            step(1'b0, 1'b0, 3'd0, 1'b1);
            m = (m == 3'd0) ? 3'(MOD_N - 1) : m - 3'd1;
            check_outputs("R6 auto cycle", m);
        end

        // R7: every digit through the normal load path
        for (int v = 0; v < 8; v++) begin
            step(1'b0, 1'b1, 3'(v), 1'b0);
            check("R7 seg digit", int'(seg), int'(segtab[v]));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule